// File: doc/BRIEF.md
# Signed-Digit Decimal Partial Product Generator

This block forms one decimal partial product in a digit-serial multiplier. One input is a multiplicand whose digits are already recoded into the signed range -5..+5. The other input is a single multiplier digit recoded the same way. The block is purely combinational. Every multiplicand position is multiplied by the multiplier digit on magnitudes. The sign is applied afterwards. Each two-digit product is split into a low digit of at most 5 in magnitude and a high digit of at most 2.

Every output position then adds its own low digit to the high digit from the position below. The result is one signed digit per position with no overlap, ready for a signed-digit accumulator. The parameter `NDIG` sets the width: the multiplicand has `NDIG+1` digits and the partial product has `NDIG+2`.

Inside each digit multiplier, a zero magnitude on either side takes a bypass, and so does a magnitude of one. Only magnitude pairs drawn from 2..5 use the small product table.

Top module: `sd_pp_gen`

## Requirements
- R1: Each input digit is 4 bits in signed-magnitude form. Bit 3 is the sign (1 = negative) and bits 2:0 are the magnitude, 0..5. Multiplicand digit i sits at `mcand[4i+3:4i]`. A negative sign with magnitude 0 gives the same output as a positive zero.
- R2: Output digit j is a 5-bit two's complement value at `pp[5j+4:5j]`. The sum of digit j times 10^j over all positions equals the multiplicand value times the multiplier digit.
- R3: Every output digit lies in -7..+7.
- R4: A multiplier digit of magnitude 0 makes every output digit 0. A multiplicand digit of magnitude 0 contributes nothing to either of the two output positions it feeds.
- R5: A multiplier digit of magnitude 1 makes output digit j equal multiplicand digit j for j up to NDIG, negated when the multiplier digit is negative. In that case the top output digit is 0.
- R6: For position i the magnitude product p is split as p = 10*h + l, where h is in 0..2 and l is in -4..+5. Output digit j is l of position j plus h of position j-1.
- R7: Both parts of a position take the sign formed as the XOR of the two operand signs.
- R8: Output digit 0 carries only the low part of position 0. Output digit NDIG+1 carries only the high part of position NDIG, so it lies in -2..+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | 4*(NDIG+1) | Recoded multiplicand digits, signed-magnitude, digit 0 in the lowest nibble |
| mdig | input | 4 | Recoded multiplier digit, signed-magnitude |
| pp | output | 5*(NDIG+2) | Overlap-free partial product digits, two's complement, digit 0 lowest |

## Verification
Every one of the 121 signed digit pairs is placed at each multiplicand position in turn while the other positions carry pseudo-random digits. This separates the zero bypass, the identity bypass and the table path, and it shows whether a high part lands in the right neighbour. The all-fives operands with both multiplier signs reach the ±7 extremes and the top digit of ±2, where a wrong split threshold or a dropped carry shows. Encodings of negative zero in either operand show whether a sign leaks through a zero magnitude. Random vectors compared against the exact integer product catch any mistake that the per-digit expectation could share with the design.

// File: rtl/sdpp_pkg.sv
package sdpp_pkg;

  localparam int IN_W  = 4;
  localparam int OUT_W = 5;

  typedef enum logic [1:0] {
    SEL_ZERO  = 2'd0,
    SEL_PASSB = 2'd1,
    SEL_PASSA = 2'd2,
    SEL_TBL   = 2'd3
  } lo_sel_e;

  typedef struct packed {
    logic [1:0] hi;
    logic       lo_neg;
    logic [2:0] lo_mag;
  } split_t;

  // Product of two magnitudes in 2..5, split so the low part stays in -4..+5.
  function automatic split_t tbl_split(input logic [2:0] a, input logic [2:0] b);
    split_t     r;
    logic [5:0] p;
    p = {3'b000, a} * {3'b000, b};
    r = '0;
    if (p >= 6'd16) begin
      r.hi = 2'd2;
      if (p >= 6'd20) r.lo_mag = 3'(p - 6'd20);
      else begin
        r.lo_neg = 1'b1;
        r.lo_mag = 3'(6'd20 - p);
      end
    end else if (p >= 6'd6) begin
      r.hi = 2'd1;
      if (p >= 6'd10) r.lo_mag = 3'(p - 6'd10);
      else begin
        r.lo_neg = 1'b1;
        r.lo_mag = 3'(6'd10 - p);
      end
    end else begin
      r.lo_mag = 3'(p);
    end
    return r;
  endfunction

  // Signed-magnitude to two's complement.
  function automatic logic signed [4:0] sm_val(input logic neg, input logic [2:0] mag);
    logic signed [4:0] m;
    m = signed'({2'b00, mag});
    return neg ? -m : m;
  endfunction

endpackage

// File: rtl/sd_digit_mul.sv
module sd_digit_mul
  import sdpp_pkg::*;
(
  input  logic [3:0] md,
  input  logic [3:0] mr,
  output logic [3:0] lo_sm,
  output logic [2:0] hi_sm
);

  logic [2:0] a_mag;
  logic [2:0] b_mag;
  logic       prod_neg;
  logic       legal;
  lo_sel_e    lo_sel;
  split_t     tbl;
  logic       lo_neg_raw;
  logic [2:0] lo_mag;
  logic [1:0] hi_mag;

  assign a_mag    = md[2:0];
  assign b_mag    = mr[2:0];
  assign prod_neg = md[3] ^ mr[3];
  assign legal    = (a_mag <= 3'd5) && (b_mag <= 3'd5);
  assign tbl      = tbl_split(a_mag, b_mag);

  always_comb begin
    if (a_mag == 3'd0 || b_mag == 3'd0) lo_sel = SEL_ZERO;
    else if (a_mag == 3'd1)             lo_sel = SEL_PASSB;
    else if (b_mag == 3'd1)             lo_sel = SEL_PASSA;
    else                                lo_sel = SEL_TBL;
  end

  always_comb begin
    lo_neg_raw = 1'b0;
    lo_mag     = 3'd0;
    hi_mag     = 2'd0;
    case (lo_sel)
      SEL_ZERO:  lo_mag = 3'd0;
      SEL_PASSB: lo_mag = b_mag;
      SEL_PASSA: lo_mag = a_mag;
      SEL_TBL: begin
        lo_neg_raw = tbl.lo_neg;
        lo_mag     = tbl.lo_mag;
        hi_mag     = tbl.hi;
      end
      default: lo_mag = 3'd0;
    endcase
  end

  assign lo_sm = {(lo_neg_raw ^ prod_neg) & (lo_mag != 3'd0), lo_mag};
  assign hi_sm = {prod_neg & (hi_mag != 2'd0), hi_mag};

  always_comb begin
    if (legal) begin
      assert_lo_range_R6: assert (lo_sm[2:0] <= 3'd5)
        else $error("low part out of range");
      assert_hi_range_R6: assert (hi_sm[1:0] <= 2'd2)
        else $error("high part out of range");
      assert_value_R2: assert ((int'(sm_val(lo_sm[3], lo_sm[2:0]))
                                + 10 * int'(sm_val(hi_sm[2], {1'b0, hi_sm[1:0]})))
                               == ((prod_neg ? -1 : 1) * int'(a_mag) * int'(b_mag)))
        else $error("digit product value mismatch");
      if (a_mag == 3'd0 || b_mag == 3'd0) begin
        assert_zero_R4: assert (lo_sm == 4'd0 && hi_sm == 3'd0)
          else $error("zero operand produced nonzero part");
      end
      if (a_mag == 3'd1 || b_mag == 3'd1) begin
        assert_identity_R5: assert (hi_sm == 3'd0)
          else $error("identity path produced high part");
      end
    end
  end

endmodule

// File: rtl/sd_overlap_merge.sv
module sd_overlap_merge
  import sdpp_pkg::*;
(
  input  logic [3:0] lo_sm,
  input  logic [2:0] hi_sm,
  output logic [4:0] dig
);

  logic signed [4:0] lo_v;
  logic signed [4:0] hi_v;
  logic signed [4:0] sum_v;

  assign lo_v  = sm_val(lo_sm[3], lo_sm[2:0]);
  assign hi_v  = sm_val(hi_sm[2], {1'b0, hi_sm[1:0]});
  assign sum_v = lo_v + hi_v;
  assign dig   = sum_v;

  always_comb begin
    if (lo_sm[2:0] <= 3'd5 && hi_sm[1:0] <= 2'd2) begin
      assert_digit_range_R3: assert (sum_v >= -5'sd7 && sum_v <= 5'sd7)
        else $error("merged digit out of range");
    end
  end

endmodule

// File: rtl/sd_pp_gen.sv
module sd_pp_gen
  import sdpp_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic [IN_W*(NDIG+1)-1:0]  mcand,
  input  logic [IN_W-1:0]           mdig,
  output logic [OUT_W*(NDIG+2)-1:0] pp
);

  localparam int NPOS = NDIG + 1;
  localparam int NOUT = NDIG + 2;

  logic [3:0] lo_sm [NPOS];
  logic [2:0] hi_sm [NPOS];

  for (genvar i = 0; i < NPOS; i++) begin : g_pos
    sd_digit_mul u_mul (
      .md    (mcand[IN_W*i +: IN_W]),
      .mr    (mdig),
      .lo_sm (lo_sm[i]),
      .hi_sm (hi_sm[i])
    );
  end

  for (genvar j = 0; j < NOUT; j++) begin : g_out
    if (j == 0) begin : g_low
      sd_overlap_merge u_mrg (
        .lo_sm (lo_sm[0]),
        .hi_sm (3'b000),
        .dig   (pp[OUT_W*j +: OUT_W])
      );
    end else if (j == NOUT - 1) begin : g_top
      sd_overlap_merge u_mrg (
        .lo_sm (4'b0000),
        .hi_sm (hi_sm[NPOS-1]),
        .dig   (pp[OUT_W*j +: OUT_W])
      );
    end else begin : g_mid
      sd_overlap_merge u_mrg (
        .lo_sm (lo_sm[j]),
        .hi_sm (hi_sm[j-1]),
        .dig   (pp[OUT_W*j +: OUT_W])
      );
    end
  end

  logic              in_legal;
  logic signed [4:0] top_dig;
  logic signed [4:0] low_dig;

  assign top_dig = pp[OUT_W*(NOUT-1) +: OUT_W];
  assign low_dig = pp[OUT_W-1:0];

  always_comb begin
    in_legal = (mdig[2:0] <= 3'd5);
    for (int i = 0; i < NPOS; i++) begin
      if (mcand[IN_W*i +: 3] > 3'd5) in_legal = 1'b0;
    end
  end

  always_comb begin
    if (in_legal) begin
      assert_top_range_R8: assert (top_dig >= -5'sd2 && top_dig <= 5'sd2)
        else $error("top digit out of range");
      assert_low_range_R8: assert (low_dig >= -5'sd5 && low_dig <= 5'sd5)
        else $error("lowest digit out of range");
    end
  end

endmodule

// File: tb/sd_pp_gen_tb.sv
module sd_pp_gen_tb;

  localparam int NDIG = 4;
  localparam int NPOS = NDIG + 1;
  localparam int NOUT = NDIG + 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [4*NPOS-1:0] mcand;
  logic [3:0]        mdig;
  logic [5*NOUT-1:0] pp;

  int n_run  = 0;
  int n_fail = 0;
  int av [NPOS];
  bit nz [NPOS];
  int bv;
  bit bnz;
  int seed = 32'h1234_5678;

  sd_pp_gen #(.NDIG(NDIG)) u_dut (
    .mcand (mcand),
    .mdig  (mdig),
    .pp    (pp)
  );

  function automatic logic [3:0] enc(int v, bit negzero);
    if (v == 0) return negzero ? 4'b1000 : 4'b0000;
    return (v < 0) ? {1'b1, 3'(-v)} : {1'b0, 3'(v)};
  endfunction

  function automatic int dec(int j);
    logic signed [4:0] d;
    d = pp[5*j +: 5];
    return int'(d);
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  // which = 0: low part, 1: high part of one position
  function automatic int part(int a, int which);
    int p, h, l, r;
    p = iabs(a) * iabs(bv);
    h = (p + 4) / 10;
    l = p - 10 * h;
    r = which ? h : l;
    return ((a < 0) != (bv < 0)) ? -r : r;
  endfunction

  function automatic int exp_dig(int j);
    int e;
    e = 0;
    if (j < NPOS) e += part(av[j], 0);
    if (j > 0)    e += part(av[j-1], 1);
    return e;
  endfunction

  function automatic int rnd_digit();
    seed = seed * 1103515245 + 12345;
    return ((seed >> 16) & 32'h7fff) % 11 - 5;
  endfunction

  task automatic drive();
    @(posedge clk);
    for (int i = 0; i < NPOS; i++) mcand[4*i +: 4] = enc(av[i], nz[i]);
    mdig = enc(bv, bnz);
    @(negedge clk);
  endtask

  task automatic clear_ops();
    for (int i = 0; i < NPOS; i++) begin
      av[i] = 0;
      nz[i] = 1'b0;
    end
    bv  = 0;
    bnz = 1'b0;
  endtask

  task automatic check_eq(string req, int got, int exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Full vector check: per-digit split, range and exact value.
  task automatic check_vec(string req);
    int  a_val, p_val, got, e, bad_j;
    bit  bad;
    n_run++;
    bad   = 1'b0;
    bad_j = -1;
    a_val = 0;
    p_val = 0;
    for (int i = NPOS - 1; i >= 0; i--) a_val = a_val * 10 + av[i];
    for (int j = NOUT - 1; j >= 0; j--) p_val = p_val * 10 + dec(j);
    for (int j = 0; j < NOUT; j++) begin
      got = dec(j);
      e   = exp_dig(j);
      if (!bad && (got != e || got < -7 || got > 7)) begin
        bad   = 1'b1;
        bad_j = j;
      end
    end
    if (bad) begin
      n_fail++;
      $display("FAIL %s: digit %0d got %0d expected %0d (b=%0d)",
               req, bad_j, dec(bad_j), exp_dig(bad_j), bv);
    end else if (p_val != a_val * bv) begin
      n_fail++;
      $display("FAIL %s R2: value got %0d expected %0d", req, p_val, a_val * bv);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    mcand = '0;
    mdig  = '0;
    clear_ops();
    drive();
    // Idle state: all-zero operands give an all-zero product (R4)
    check_eq("R4 idle", int'(pp), 0);

    // R4: zero multiplier with busy multiplicand, R1: negative zero multiplier
    for (int k = 0; k < 20; k++) begin
      for (int i = 0; i < NPOS; i++) av[i] = rnd_digit();
      bv  = 0;
      bnz = (k % 2 == 1);
      drive();
      check_eq(bnz ? "R1 R4 neg-zero multiplier" : "R4 zero multiplier", int'(pp), 0);
    end
    bnz = 1'b0;

    // R5: identity multiplier digits
    for (int k = 0; k < 20; k++) begin
      for (int i = 0; i < NPOS; i++) av[i] = rnd_digit();
      bv = (k % 2 == 0) ? 1 : -1;
      drive();
      for (int j = 0; j < NPOS; j++) check_eq("R5 identity digit", dec(j), av[j] * bv);
      check_eq("R5 identity top", dec(NOUT - 1), 0);
    end

    // R6 R7: every signed pair at every position, neighbours pseudo-random
    for (int b = -5; b <= 5; b++) begin
      for (int a = -5; a <= 5; a++) begin
        for (int pos = 0; pos < NPOS; pos++) begin
          for (int i = 0; i < NPOS; i++) av[i] = rnd_digit();
          av[pos] = a;
          bv      = b;
          drive();
          check_vec("R6 R7 sweep");
        end
      end
    end

    // R1: negative-zero multiplicand digits behave like zero (R4 no contribution)
    for (int k = 0; k < 30; k++) begin
      for (int i = 0; i < NPOS; i++) begin
        av[i] = rnd_digit();
        nz[i] = (av[i] == 0) || (i == k % NPOS);
        if (i == k % NPOS) av[i] = 0;
      end
      bv = rnd_digit();
      drive();
      check_vec("R1 R4 neg-zero multiplicand");
    end
    for (int i = 0; i < NPOS; i++) nz[i] = 1'b0;

    // R3 R8: extremes with all fives
    for (int i = 0; i < NPOS; i++) av[i] = 5;
    bv = 5;
    drive();
    check_eq("R8 low digit", dec(0), 5);
    for (int j = 1; j < NOUT - 1; j++) check_eq("R3 max digit", dec(j), 7);
    check_eq("R8 top digit", dec(NOUT - 1), 2);
    bv = -5;
    drive();
    check_eq("R8 low digit neg", dec(0), -5);
    for (int j = 1; j < NOUT - 1; j++) check_eq("R3 min digit", dec(j), -7);
    check_eq("R8 top digit neg", dec(NOUT - 1), -2);

    // R6 split boundaries: 4*4=16 -> 2,-4 ; 3*5=15 -> 1,5
    clear_ops();
    av[0] = 4; bv = 4;
    drive();
    check_eq("R6 split 16 low", dec(0), -4);
    check_eq("R6 split 16 high", dec(1), 2);
    av[0] = 3; bv = 5;
    drive();
    check_eq("R6 split 15 low", dec(0), 5);
    check_eq("R6 split 15 high", dec(1), 1);

    // R2: random vectors against exact value
    for (int k = 0; k < 1500; k++) begin
      for (int i = 0; i < NPOS; i++) av[i] = rnd_digit();
      bv = rnd_digit();
      drive();
      check_vec("R2 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule